// File: doc/BRIEF.md
# Prescaled Tick Timer with Overflow and Periodic Interrupts

This block is a free-running binary counter chain that advances on every bus clock. A prescaler of four bus cycles sits at its bottom, and the eight stages above the prescaler can be read as a count byte. When that byte wraps, an overflow flag is raised. A second flag, the periodic flag, is raised on each rising edge of one of four high taps of the chain. A 2-bit rate field picks the tap. The selected tap also leaves the block as a one-cycle tick pulse, which an external watchdog uses as its time base.

Software reaches the block through a plain register port with a one-bit address. Address 0 is the control/status byte, which holds the two flags, their interrupt enables, two write-only flag-clear bits and the rate field. Address 1 is the count byte, which is read-only. Reads are combinational. A write takes effect at the clock edge at which `wr_i` is sampled high. The interrupt output is the OR of the two enabled flags. An active-low asynchronous reset stands in for power-on reset. It clears the whole chain and holds it at zero until the reset is released.

Top module: `tick_timer`

## Requirements
- R1: While `rst_ni` is low and directly after its release: the control byte reads 0x03, the count byte reads 0x00, `irq_o` is 0 and `tick_o` is 0. Asserting reset mid-run restores this state.
- R2: After N clock edges since the release of reset, the count byte (`sel_i`=1) reads (N / 2^PRE_W) mod 256. With the default PRE_W=2, one count spans four bus cycles.
- R3: Bit 7 of the control byte (the overflow flag) becomes 1 one edge after the count wraps from 0xFF to 0x00. This first happens at N = 2^(PRE_W+8)+1 and then recurs every 2^(PRE_W+8) edges. The flag stays set until it is cleared.
- R4: With rate code c in bits 1:0, tap bit TAP_BASE+c of the chain is selected. `tick_o` is high for exactly the one cycle in which N mod 2^(TAP_BASE+c+1) equals 2^(TAP_BASE+c). Bit 6 (the periodic flag) becomes 1 on the next edge.
- R5: Bit 5 (overflow enable), bit 4 (periodic enable) and bits 1:0 (rate) read back as written. Bits 3 and 2 always read 0.
- R6: A control write with bit 3 set clears the overflow flag, and a control write with bit 2 set clears the periodic flag. A 0 in those bits leaves the flags unchanged, and bits 7 and 6 of a write have no effect.
- R7: If a flag-set event and a write that clears the same flag land on the same edge, the flag ends up set.
- R8: `irq_o` is 1 exactly when (bit 7 and bit 5) or (bit 6 and bit 4) of the control byte are both set.
- R9: A write to address 1 changes neither the count byte nor the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sel_i | input | 1 | Register select: 0 = control/status, 1 = count |
| wr_i | input | 1 | Write strobe, sampled at the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for the register selected by `sel_i` |
| irq_o | output | 1 | Combined interrupt request |
| tick_o | output | 1 | One-cycle pulse on each rising edge of the selected tap, for the watchdog |

## Verification
The count byte and the readback of the rate and enable fields follow the edge that causes them with no further delay. `tick_o` goes high in the cycle that follows the edge on which the tap rises. The flags and `irq_o` change one edge after that. The bench tracks its own count of edges since the release of reset and derives every expected value from that count. It samples at the falling clock edge and drives writes there too, so the edge that takes a write is always known. The flag-clear race is staged by issuing the clear on the exact edge that sets the flag.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int CNT_W   = 8;
  localparam int RATE_W  = 2;
  localparam int NTAP    = 1 << RATE_W;
  // control byte bit positions (software decodes these)
  localparam int B_OVF   = 7;
  localparam int B_PER   = 6;
  localparam int B_OVIE  = 5;
  localparam int B_PERIE = 4;
  localparam int B_OVCLR = 3;
  localparam int B_PECLR = 2;
  localparam logic [RATE_W-1:0] RATE_RST = '1;

  typedef struct packed {
    logic              ovf;
    logic              per;
    logic              ovie;
    logic              perie;
    logic [RATE_W-1:0] rate;
  } ctl_t;

  function automatic logic [7:0] ctl_byte(input ctl_t c);
    logic [7:0] b;
    b = '0;
    b[B_OVF]   = c.ovf;
    b[B_PER]   = c.per;
    b[B_OVIE]  = c.ovie;
    b[B_PERIE] = c.perie;
    b[RATE_W-1:0] = c.rate;
    return b;
  endfunction
endpackage

// File: rtl/tt_chain.sv
module tt_chain #(
  parameter int PRE_W    = 2,
  parameter int TAP_BASE = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [tt_pkg::RATE_W-1:0] rate_i,
  output logic [tt_pkg::CNT_W-1:0] cnt_o,
  output logic                     wrap_lvl_o,
  output logic                     tap_o
);
  localparam int LOW_W   = PRE_W + tt_pkg::CNT_W;
  localparam int HIGH_W  = TAP_BASE + tt_pkg::NTAP;
  localparam int CHAIN_W = (LOW_W > HIGH_W) ? LOW_W : HIGH_W;

  logic [CHAIN_W-1:0]      chain_q;
  logic [tt_pkg::NTAP-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_q + 1'b1;
  end

  for (genvar i = 0; i < tt_pkg::NTAP; i++) begin : g_tap
    assign taps[i] = chain_q[TAP_BASE+i];
  end

  assign cnt_o      = chain_q[LOW_W-1:PRE_W];
  assign wrap_lvl_o = chain_q[LOW_W-1];
  assign tap_o      = taps[rate_i];
endmodule

// File: rtl/tt_edge.sv
module tt_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  if (FALLING) begin : g_fall
    assign pulse_o = prev_q & ~lvl_i;
  end else begin : g_rise
    assign pulse_o = lvl_i & ~prev_q;
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_ctl_i,
  input  logic [7:0]   wdata_i,
  input  logic         ovf_evt_i,
  input  logic         per_evt_i,
  output tt_pkg::ctl_t ctl_o
);
  import tt_pkg::*;

  ctl_t ctl_q;
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[B_OVF], wdata_i[B_PER]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q.ovf   <= 1'b0;
      ctl_q.per   <= 1'b0;
      ctl_q.ovie  <= 1'b0;
      ctl_q.perie <= 1'b0;
      ctl_q.rate  <= RATE_RST;
    end else begin
      if (ovf_evt_i)                        ctl_q.ovf <= 1'b1;
      else if (wr_ctl_i && wdata_i[B_OVCLR]) ctl_q.ovf <= 1'b0;
      if (per_evt_i)                        ctl_q.per <= 1'b1;
      else if (wr_ctl_i && wdata_i[B_PECLR]) ctl_q.per <= 1'b0;
      if (wr_ctl_i) begin
        ctl_q.ovie  <= wdata_i[B_OVIE];
        ctl_q.perie <= wdata_i[B_PERIE];
        ctl_q.rate  <= wdata_i[RATE_W-1:0];
      end
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int PRE_W    = 2,
  parameter int TAP_BASE = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       tick_o
);
  import tt_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             wrap_lvl, tap_lvl, ovf_evt, per_evt, wr_ctl;
  ctl_t             ctl;

  assign wr_ctl = wr_i & ~sel_i;

  tt_chain #(.PRE_W(PRE_W), .TAP_BASE(TAP_BASE)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(ctl.rate),
    .cnt_o(cnt), .wrap_lvl_o(wrap_lvl), .tap_o(tap_lvl)
  );

  tt_edge #(.FALLING(1'b1)) u_wrap_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(wrap_lvl), .pulse_o(ovf_evt)
  );

  tt_edge #(.FALLING(1'b0)) u_tap_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(tap_lvl), .pulse_o(per_evt)
  );

  tt_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ctl_i(wr_ctl), .wdata_i(wdata_i),
    .ovf_evt_i(ovf_evt), .per_evt_i(per_evt), .ctl_o(ctl)
  );

  assign rdata_o = sel_i ? cnt : ctl_byte(ctl);
  assign irq_o   = (ctl.ovf & ctl.ovie) | (ctl.per & ctl.perie);
  assign tick_o  = per_evt;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       tick_o,
  input logic [7:0] cnt,
  input logic       ovf_evt,
  input logic       ovf_flag,
  input logic       per_flag
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2: the count byte holds or steps by exactly one
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cnt != $past(cnt)) |-> cnt == $past(cnt) + 8'd1);

  // R3: the overflow flag rises only when the count has just wrapped to zero
  p_ovf_at_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(ovf_flag)) |-> cnt == 8'd0);

  // R4: the tick is a single-cycle pulse
  p_tick_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R6: a clear with no competing set empties the flag
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && wdata_i[3] && !ovf_evt) |=> !ovf_flag);

  // R7: a set event always leaves the flag set
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ovf_flag);

  // R8: no interrupt without a pending flag
  p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_flag || per_flag));

  // R5: the clear bits never read back as 1
  p_clr_bits_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> rdata_o[3:2] == 2'b00);
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .tick_o(tick_o),
  .cnt(cnt), .ovf_evt(ovf_evt), .ovf_flag(ctl.ovf), .per_flag(ctl.per)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam int PRE_W = 2;
  localparam int TAPB  = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, tick;
  int         edges = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tick_timer #(.PRE_W(PRE_W), .TAP_BASE(TAPB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .tick_o(tick)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s edges=%0d actual=0x%0h expected=0x%0h", req, edges, act, exp);
    end
  endtask

  task automatic rd(input bit a, output logic [7:0] v);
    sel = a;
    #1;
    v = rdata;
  endtask

  task automatic wr_reg(input bit a, input logic [7:0] d);
    sel = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired edges=%0d actual=0 expected=1", edges);
    summary();
  end

  initial begin
    logic [7:0] v, c;
    int p;
    // R1: state during reset
    repeat (2) @(negedge clk);
    rd(0, v); chk(v == 8'h03, "R1 ctrl in reset", v, 8'h03);
    rd(1, v); chk(v == 8'h00, "R1 count in reset", v, 0);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    rst_n = 1'b1;

    // R2/R3/R4/R8: free run at the reset rate (code 11)
    while (edges <= 4200) begin
      rd(1, v);
      chk(v == 8'((edges >> PRE_W) & 255), "R2 count", v, (edges >> PRE_W) & 255);
      rd(0, c);
      chk(c[7] == (edges >= 1025), "R3 overflow flag", c[7], edges >= 1025);
      chk(c[6] == (edges >= (1 << (TAPB+3)) + 1), "R4 periodic flag", c[6], 0);
      chk(tick == (edges == (1 << (TAPB+3))), "R4 tick", tick, 0);
      chk(irq == 1'b0, "R8 irq with enables off", irq, 0);
      if (edges == 0) chk(c == 8'h03, "R1 ctrl after release", c, 8'h03);
      @(negedge clk);
    end

    // R6/R5: clear both, then check flags and clear bits
    wr_reg(0, 8'h0F);
    rd(0, v); chk(v == 8'h03, "R6 clear both flags", v, 8'h03);
    wr_reg(0, 8'hC3);
    rd(0, v); chk(v[7:6] == 2'b00, "R6 write to flag bits ignored", v[7:6], 0);
    run_to(5125);
    rd(0, v); chk(v[7] == 1'b1, "R3 overflow recurs", v[7], 1);
    wr_reg(0, 8'h03);
    rd(0, v); chk(v[7] == 1'b1, "R6 zero in clear bit keeps flag", v[7], 1);
    wr_reg(0, 8'h36);
    rd(0, v); chk((v & 8'h3F) == 8'h32, "R5 readback", v & 8'h3F, 8'h32);
    // R9: count byte is read-only
    wr_reg(1, 8'h55);
    rd(1, v);
    chk(v == 8'((edges >> PRE_W) & 255), "R9 count write ignored", v, (edges >> PRE_W) & 255);
    rd(0, c); chk((c & 8'h3F) == 8'h32, "R9 ctrl unchanged", c & 8'h3F, 8'h32);

    // R1: reset mid-run
    do_reset();
    rd(0, v); chk(v == 8'h03, "R1 ctrl after mid-run reset", v, 8'h03);
    rd(1, v); chk(v == 8'h00, "R1 count after mid-run reset", v, 0);
    chk(irq == 1'b0 && tick == 1'b0, "R1 outputs after mid-run reset", {irq, tick}, 0);

    // R7: clear lands on the setting edge
    run_to(1024);
    wr_reg(0, 8'h0B);
    rd(0, v); chk(v[7] == 1'b1, "R7 set wins over clear", v[7], 1);
    wr_reg(0, 8'h0B);
    rd(0, v); chk(v[7] == 1'b0, "R6 later clear", v[7], 0);

    // R8: overflow enable path
    do_reset();
    wr_reg(0, 8'h23);
    while (edges <= 1030) begin
      chk(irq == (edges >= 1025), "R8 overflow irq", irq, edges >= 1025);
      @(negedge clk);
    end
    wr_reg(0, 8'h2B);
    chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);

    // R4/R8: every rate code, periodic enable only
    for (int code = 0; code < 4; code++) begin
      do_reset();
      wr_reg(0, 8'h10 | 8'(code));
      p = 1 << (TAPB + code);
      while (edges <= 3 * p + 4) begin
        rd(0, c);
        chk(tick == ((edges % (2 * p)) == p), "R4 tick per rate", tick, (edges % (2 * p)) == p);
        chk(c[6] == (edges >= p + 1), "R4 flag per rate", c[6], edges >= p + 1);
        chk(irq == (edges >= p + 1), "R8 periodic irq", irq, edges >= p + 1);
        @(negedge clk);
      end
    end
    summary();
  end
endmodule